// File: doc/BRIEF.md
# Edge-Compensated Pulse Timestamp Unit

This unit timestamps the rising edges of a slow external pulse, such as a once-per-second marker. Two counters advance on a shared tick taken at one quarter of the system clock. A free-running reference count wraps at its top value. An elapsed count restarts from zero whenever a rising edge is detected on the synchronized input.

Software may poll long after the edge. A read strobe freezes three things in one clock: the detected level, the reference count and the elapsed count. From the frozen pair the unit forms a compensated stamp, the reference count minus the elapsed count. The stamp is the reference count at the moment the edge was detected, however late the poll arrives.

The unit also has several flags. A per-poll flag marks a low-to-high change between two polls. A sticky flag reports that an edge arrived since the last read. An overrun flag reports that the elapsed count hit its ceiling. An echo output mirrors the polled level, with selectable polarity, as a visual indicator.

Top module: `edge_stamp_unit`

## Requirements
- R1: After reset every snapshot output, the stamp and all three flags are zero, and echoOut equals echoInvert.
- R2: The reference count rises by one on every TICK_DIV-th clock after reset and wraps from all ones to zero. Seen through a read strobe sampled at clock edge m (edges counted from 1 after reset release), refSnap is floor((m-1)/TICK_DIV) modulo 2^CNT_W.
- R3: The input passes through two synchronizer flops and is then edge-detected. The elapsed count is cleared at clock edge e+3 when eventIn rises just after edge e, and it then counts on every tick.
- R4: A read strobe captures the detected level, the reference count and the elapsed count in the same clock. The captured values hold until the next strobe.
- R5: stampOut equals refSnap minus elapsedSnap modulo 2^CNT_W. After an edge detected at clock edge k, it equals floor(k/TICK_DIV) modulo 2^CNT_W.
- R6: assertEvent is 1 after a poll only when the newly captured level is 1 and the previous captured level was 0. A poll that sees high then high, or a high-to-low change, gives 0.
- R7: echoOut equals levelSnap XOR echoInvert. It goes active after an asserting poll and inactive after the next deasserting poll; echoInvert=1 makes active mean low.
- R8: newFlag sets on a detected rising edge and clears on a read strobe. When both happen in the same clock, the flag stays set.
- R9: The elapsed count saturates at all ones. overrunFlag sets in the clock where it reaches that value, and it clears on a read strobe.
- R10: A falling input edge neither clears the elapsed count, nor sets newFlag, nor changes a later stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| eventIn | input | 1 | External pulse input, asynchronous |
| readStrobe | input | 1 | One-clock poll request that captures the snapshot |
| echoInvert | input | 1 | 1 makes the echo active low |
| refSnap | output | CNT_W | Captured reference count |
| elapsedSnap | output | CNT_W | Captured elapsed count |
| stampOut | output | CNT_W | Compensated stamp, reference minus elapsed |
| levelSnap | output | 1 | Captured detected level |
| assertEvent | output | 1 | Low-to-high change between the last two polls |
| newFlag | output | 1 | Sticky: edge seen since the last read |
| overrunFlag | output | 1 | Elapsed count reached its ceiling |
| echoOut | output | 1 | Polled level with selectable polarity |

## Verification
The bench builds the unit with CNT_W=8 and the default TICK_DIV=4. With these values the elapsed ceiling and the reference wrap both arrive after about a thousand clocks, so saturation, the overrun flag and the modulo arithmetic of the stamp are all checked within a short run. The read strobe is also placed on the exact clock of edge detection, to show that the new flag wins over the clear and that the snapshot still shows the old level.

// File: rtl/edge_stamp_pkg.sv
`timescale 1ns/1ps
package edge_stamp_pkg;
  // Strobes passed from control to datapath each clock
  typedef struct packed {
    logic tick;     // counters advance this clock
    logic rise;     // rising edge detected on synchronized input
    logic capture;  // snapshot request
    logic level;    // detected level, consistent with the counters
  } stampCtl_t;
endpackage

// File: rtl/estamp_counter.sv
`timescale 1ns/1ps
module estamp_counter #(
  parameter int CNT_W    = 16,
  parameter bit SATURATE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             reachMax
);
  localparam logic [CNT_W-1:0] TOP_VAL  = '1;
  localparam logic [CNT_W-1:0] NEAR_TOP = TOP_VAL - 1'b1;

  logic [CNT_W-1:0] countNext;

  generate
    if (SATURATE) begin : g_sat
      always_comb countNext = (count == TOP_VAL) ? count : count + 1'b1;
    end else begin : g_wrap
      always_comb countNext = count + 1'b1;
    end
  endgenerate

  // high in the clock where the count is about to land on the top value
  assign reachMax = step && !clear && (count == NEAR_TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= countNext;
  end
endmodule

// File: rtl/estamp_ctrl.sv
`timescale 1ns/1ps
module estamp_ctrl
  import edge_stamp_pkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      eventIn,
  input  logic      readStrobe,
  output stampCtl_t ctl,
  output logic      newFlag
);
  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0]       divCnt;
  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   detLevel;
  logic                   tickNow;
  logic                   riseNow;

  // tick divider
  assign tickNow = (divCnt == DIV_LAST);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (tickNow) divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end

  // input synchronizer
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncPipe[0] <= 1'b0;
          else       syncPipe[0] <= eventIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncPipe[s] <= 1'b0;
          else       syncPipe[s] <= syncPipe[s-1];
        end
      end
    end
  endgenerate

  // detected level updates in the same edge that clears the elapsed count
  assign riseNow = syncPipe[SYNC_STAGES-1] & ~detLevel;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) detLevel <= 1'b0;
    else       detLevel <= syncPipe[SYNC_STAGES-1];
  end

  // sticky edge flag; a new edge wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           newFlag <= 1'b0;
    else if (riseNow)    newFlag <= 1'b1;
    else if (readStrobe) newFlag <= 1'b0;
  end

  always_comb begin
    ctl.tick    = tickNow;
    ctl.rise    = riseNow;
    ctl.capture = readStrobe;
    ctl.level   = detLevel;
  end
endmodule

// File: rtl/estamp_datapath.sv
`timescale 1ns/1ps
module estamp_datapath
  import edge_stamp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stampCtl_t        ctl,
  input  logic             echoInvert,
  output logic [CNT_W-1:0] refNow,
  output logic [CNT_W-1:0] elapsedNow,
  output logic [CNT_W-1:0] refSnap,
  output logic [CNT_W-1:0] elapsedSnap,
  output logic [CNT_W-1:0] stampOut,
  output logic             levelSnap,
  output logic             assertEvent,
  output logic             overrunFlag,
  output logic             echoOut
);
  logic refWrapUnused;
  logic elapsedFull;

  estamp_counter #(.CNT_W(CNT_W), .SATURATE(1'b0)) refCounter (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (1'b0),
    .step     (ctl.tick),
    .count    (refNow),
    .reachMax (refWrapUnused)
  );

  estamp_counter #(.CNT_W(CNT_W), .SATURATE(1'b1)) elapsedCounter (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (ctl.rise),
    .step     (ctl.tick),
    .count    (elapsedNow),
    .reachMax (elapsedFull)
  );

  // overrun: set when the elapsed count lands on its ceiling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            overrunFlag <= 1'b0;
    else if (elapsedFull) overrunFlag <= 1'b1;
    else if (ctl.capture) overrunFlag <= 1'b0;
  end

  // single-clock snapshot of level and both counts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSnap     <= '0;
      elapsedSnap <= '0;
      stampOut    <= '0;
      levelSnap   <= 1'b0;
      assertEvent <= 1'b0;
    end else if (ctl.capture) begin
      refSnap     <= refNow;
      elapsedSnap <= elapsedNow;
      stampOut    <= refNow - elapsedNow;
      levelSnap   <= ctl.level;
      assertEvent <= ctl.level & ~levelSnap;
    end
  end

  assign echoOut = levelSnap ^ echoInvert;
endmodule

// File: rtl/edge_stamp_unit.sv
`timescale 1ns/1ps
module edge_stamp_unit
  import edge_stamp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eventIn,
  input  logic             readStrobe,
  input  logic             echoInvert,
  output logic [CNT_W-1:0] refSnap,
  output logic [CNT_W-1:0] elapsedSnap,
  output logic [CNT_W-1:0] stampOut,
  output logic             levelSnap,
  output logic             assertEvent,
  output logic             newFlag,
  output logic             overrunFlag,
  output logic             echoOut
);
  stampCtl_t        ctl;
  logic [CNT_W-1:0] refNow;
  logic [CNT_W-1:0] elapsedNow;

  estamp_ctrl #(.TICK_DIV(TICK_DIV), .SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .eventIn    (eventIn),
    .readStrobe (readStrobe),
    .ctl        (ctl),
    .newFlag    (newFlag)
  );

  estamp_datapath #(.CNT_W(CNT_W)) datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .echoInvert  (echoInvert),
    .refNow      (refNow),
    .elapsedNow  (elapsedNow),
    .refSnap     (refSnap),
    .elapsedSnap (elapsedSnap),
    .stampOut    (stampOut),
    .levelSnap   (levelSnap),
    .assertEvent (assertEvent),
    .overrunFlag (overrunFlag),
    .echoOut     (echoOut)
  );
endmodule

// File: rtl/edge_stamp_unit_checker.sv
`timescale 1ns/1ps
module edge_stamp_unit_checker
  import edge_stamp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             readStrobe,
  input logic             echoInvert,
  input stampCtl_t        ctl,
  input logic [CNT_W-1:0] refNow,
  input logic [CNT_W-1:0] elapsedNow,
  input logic [CNT_W-1:0] refSnap,
  input logic [CNT_W-1:0] elapsedSnap,
  input logic [CNT_W-1:0] stampOut,
  input logic             levelSnap,
  input logic             assertEvent,
  input logic             newFlag,
  input logic             overrunFlag,
  input logic             echoOut
);
  p_ref_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.tick |=> refNow == CNT_W'($past(refNow) + 1'b1));

  p_elapsed_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rise |=> elapsedNow == '0);

  p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !readStrobe |=> $stable(refSnap) && $stable(elapsedSnap) && $stable(levelSnap));

  p_stamp_diff_r5: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe |=> stampOut == CNT_W'(refSnap - elapsedSnap));

  p_assert_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    assertEvent |-> levelSnap);

  p_echo_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(readStrobe) && $stable(echoInvert) |-> $stable(echoOut));

  p_new_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rise |=> newFlag);

  p_new_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe && !ctl.rise |=> !newFlag);

  p_overrun_sat_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> elapsedNow == '1);
endmodule

bind edge_stamp_unit edge_stamp_unit_checker #(.CNT_W(CNT_W)) stampChecker (
  .clk         (clk),
  .rstN        (rstN),
  .readStrobe  (readStrobe),
  .echoInvert  (echoInvert),
  .ctl         (ctl),
  .refNow      (refNow),
  .elapsedNow  (elapsedNow),
  .refSnap     (refSnap),
  .elapsedSnap (elapsedSnap),
  .stampOut    (stampOut),
  .levelSnap   (levelSnap),
  .assertEvent (assertEvent),
  .newFlag     (newFlag),
  .overrunFlag (overrunFlag),
  .echoOut     (echoOut)
);

// File: tb/edge_stamp_unit_test.sv
`timescale 1ns/1ps
module edge_stamp_unit_test;
  localparam int CNT_W    = 8;
  localparam int TICK_DIV = 4;
  localparam int TOP      = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eventIn = 1'b0;
  logic readStrobe = 1'b0;
  logic echoInvert = 1'b0;
  logic [CNT_W-1:0] refSnap, elapsedSnap, stampOut;
  logic levelSnap, assertEvent, newFlag, overrunFlag, echoOut;

  int checkCount = 0;
  int failCount  = 0;
  int edgeCount  = 0;
  int kRise      = 0;
  int pollEdge   = 0;
  bit done       = 1'b0;

  edge_stamp_unit #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) uut (
    .clk, .rstN, .eventIn, .readStrobe, .echoInvert,
    .refSnap, .elapsedSnap, .stampOut, .levelSnap,
    .assertEvent, .newFlag, .overrunFlag, .echoOut
  );

  always #10 clk = ~clk;

  always @(posedge clk) if (rstN) edgeCount <= edgeCount + 1;

  // reference model values
  function automatic int refAt(input int m);
    return ((m - 1) / TICK_DIV) % (TOP + 1);
  endfunction
  function automatic int elapsedAt(input int m);
    int d = (m - 1) / TICK_DIV - kRise / TICK_DIV;
    return (d > TOP) ? TOP : d;
  endfunction
  function automatic int stampExp();
    return (kRise / TICK_DIV) % (TOP + 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitClocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll();
    @(negedge clk);
    pollEdge = edgeCount + 1;
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic raiseInput();
    @(negedge clk);
    eventIn = 1'b1;
    kRise = edgeCount + 3;
  endtask

  task automatic t_reset();
    check("R1 refSnap", refSnap, 0);
    check("R1 elapsedSnap", elapsedSnap, 0);
    check("R1 stampOut", stampOut, 0);
    check("R1 levelSnap", levelSnap, 0);
    check("R1 assertEvent", assertEvent, 0);
    check("R1 newFlag", newFlag, 0);
    check("R1 overrunFlag", overrunFlag, 0);
    check("R1 echoOut", echoOut, 0);
  endtask

  task automatic t_idle_poll();
    waitClocks(37);
    poll();
    check("R2 refSnap idle", refSnap, refAt(pollEdge));
    check("R3 elapsedSnap idle", elapsedSnap, elapsedAt(pollEdge));
    check("R5 stamp idle", stampOut, 0);
    check("R6 no assert idle", assertEvent, 0);
  endtask

  task automatic t_rise_poll();
    raiseInput();
    waitClocks(50);
    check("R8 newFlag set", newFlag, 1);
    poll();
    check("R4 levelSnap", levelSnap, 1);
    check("R6 assertEvent", assertEvent, 1);
    check("R2 refSnap", refSnap, refAt(pollEdge));
    check("R3 elapsedSnap", elapsedSnap, elapsedAt(pollEdge));
    check("R5 stamp", stampOut, stampExp());
    check("R7 echo active", echoOut, 1);
    check("R8 newFlag cleared", newFlag, 0);
  endtask

  task automatic t_repeat_poll();
    waitClocks(10);
    poll();
    check("R6 high-high no assert", assertEvent, 0);
    check("R5 stamp repeat", stampOut, stampExp());
    check("R3 elapsedSnap repeat", elapsedSnap, elapsedAt(pollEdge));
  endtask

  task automatic t_fall();
    @(negedge clk);
    eventIn = 1'b0;
    waitClocks(20);
    check("R10 newFlag after fall", newFlag, 0);
    poll();
    check("R4 levelSnap low", levelSnap, 0);
    check("R6 fall no assert", assertEvent, 0);
    check("R10 elapsed not cleared", elapsedSnap, elapsedAt(pollEdge));
    check("R10 stamp unchanged", stampOut, stampExp());
    check("R7 echo inactive", echoOut, 0);
    echoInvert = 1'b1;
    #1;
    check("R7 echo inverted", echoOut, 1);
    @(negedge clk);
    echoInvert = 1'b0;
  endtask

  task automatic t_set_wins();
    raiseInput();
    @(negedge clk);
    @(negedge clk);
    pollEdge = edgeCount + 1;
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
    check("R4 same-clock snapshot level", levelSnap, 0);
    check("R8 set wins over clear", newFlag, 1);
    waitClocks(30);
    poll();
    check("R6 assert after set-wins", assertEvent, 1);
    check("R5 stamp set-wins", stampOut, stampExp());
    check("R3 elapsedSnap set-wins", elapsedSnap, elapsedAt(pollEdge));
  endtask

  task automatic t_overrun();
    waitClocks(100);
    check("R9 no overrun yet", overrunFlag, 0);
    waitClocks(1100);
    check("R9 overrun set", overrunFlag, 1);
    poll();
    check("R9 elapsed saturated", elapsedSnap, TOP);
    check("R2 ref wrapped", refSnap, refAt(pollEdge));
    check("R9 overrun cleared", overrunFlag, 0);
    waitClocks(100);
    check("R9 overrun stays clear", overrunFlag, 0);
  endtask

  initial begin
    waitClocks(3);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_poll();
    t_rise_poll();
    t_repeat_poll();
    t_fall();
    t_set_wins();
    t_overrun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end
endmodule